// File: doc/BRIEF.md
# Quad Decrementing Timer Unit

A memory-mapped peripheral holding four independent down-counters with a shared interrupt bank. Software programs each counter through four word registers: a load value that takes effect at once, a live count, a control byte and a background value. The background value is only used when a periodic counter hits zero. Each counter can run free, reload periodically or fire once. It is clocked through its own prescaler, which divides the bus clock by 1, 16 or 256.

Each expiry latches a raw status bit. A mask register picks which status bits reach the single interrupt output, and a write-one-to-clear register removes handled events. The register port is single-cycle. A write takes effect at the clock edge on which `wr_en` is sampled. `rdata` is registered: it shows, after the next edge, the value at the address presented in the cycle before.

Top module: `qtimer_top`

## Requirements
- R1: Shared registers are at byte offsets 0x00 (mask), 0x04 (raw status), 0x08 (raw AND mask) and 0x0C (clear, reads 0); bit n of each belongs to counter n and only bits below the channel count exist. Counter n occupies 0x10+0x10*n with +0x0 load, +0x4 live count (read-only), +0x8 control, +0xC background value. Unmapped or non-word-aligned addresses read 0 and ignore writes. Read data appears on `rdata` one clock after the address.
- R2: Control bit 7 enables, bit 6 selects periodic, bits 3:2 select the prescale, bit 1 selects 32-bit width and bit 0 selects one-shot; the other bits read back 0. After reset every register, `rdata` and `irq` are 0.
- R3: A load write sets the count to the written value at that edge, also while counting, and the value reads back at +0x0.
- R4: Prescale code 00 decrements every clock, 01 every 16 clocks and 10 or 11 every 256 clocks, one step per decrement. A control write restarts the divider, so the first decrement lands exactly one divide ratio of edges after the control-write edge.
- R5: A decrement from 1 to 0 is an expiry: the raw status bit is set at that edge and `irq` (if masked in) rises one edge later.
- R6: A free-running counter that is at zero wraps to all ones of its active width on the next decrement, with no extra expiry.
- R7: A periodic counter at zero loads the background value on its next decrement, giving a period of background+1 decrements; writing the background value never disturbs the live count.
- R8: A one-shot counter that reaches zero stays at zero while enabled, and one-shot wins over the periodic bit.
- R9: With bit 1 clear only the low 16 bits count: the live count reads back zero-extended from 16 bits, and expiry and wrap happen at 16-bit zero.
- R10: With enable clear the count is frozen; reads have no side effects on any register.
- R11: `irq` is the registered OR of raw status AND mask, and the 0x08 register reads that same AND.
- R12: Writing the clear register clears exactly the raw status bits written as one; the others are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | AW (8) | Byte address |
| wdata | input | CW (32) | Write data |
| rdata | output | CW (32) | Registered read data |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench samples `irq` on exact edges after control writes under each prescale. A divider that does not restart, or that is off by one, moves the edge and is caught. Counters are frozen at chosen edges and read back to tell free-running wrap, periodic reload and one-shot hold apart. A design that mixed these modes up would show the wrong value, such as all ones where the background value was expected. The 16-bit width is exercised with a set upper half, so a design that compared all 32 bits would miss the expiry. Partial clears, masked-off events and misaligned accesses expose a clear bank that wipes every bit, or a decoder that ignores the low address bits.

// File: rtl/qtimer_pkg.sv
package qtimer_pkg;

  // word selector inside a 16-byte group (addr[3:2])
  localparam logic [1:0] SUB_MASK  = 2'd0;
  localparam logic [1:0] SUB_RAW   = 2'd1;
  localparam logic [1:0] SUB_MSKD  = 2'd2;
  localparam logic [1:0] SUB_CLR   = 2'd3;

  localparam logic [1:0] SUB_LOAD  = 2'd0;
  localparam logic [1:0] SUB_COUNT = 2'd1;
  localparam logic [1:0] SUB_CTRL  = 2'd2;
  localparam logic [1:0] SUB_BACK  = 2'd3;

  typedef struct packed {
    logic       en;
    logic       per;
    logic [1:0] ps;
    logic       wide;
    logic       one;
  } ctrl_t;

  function automatic ctrl_t byte_to_ctrl(input logic [7:0] b);
    ctrl_t c;
    c.en   = b[7];
    c.per  = b[6];
    c.ps   = b[3:2];
    c.wide = b[1];
    c.one  = b[0];
    return c;
  endfunction

  function automatic logic [7:0] ctrl_to_byte(input ctrl_t c);
    return {c.en, c.per, 2'b00, c.ps, c.wide, c.one};
  endfunction

  // divide ratio for a prescale code; codes 10 and 11 both divide by 256
  function automatic int unsigned ps_ratio(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 16;
      default: return 256;
    endcase
  endfunction

endpackage

// File: rtl/qtimer_prescale.sv
module qtimer_prescale
  import qtimer_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       run,
  input  logic [1:0] code,
  output logic       tick
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] term;

  always_comb begin
    term = DIV_W'(ps_ratio(code) - 1);
    tick = run && (div_q == term);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
    end else if (restart || !run || tick) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/qtimer_chan.sv
module qtimer_chan
  import qtimer_pkg::*;
#(
  parameter int unsigned CW    = 32,
  parameter int unsigned HW    = 16,
  parameter int unsigned DIV_W = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_load,
  input  logic          wr_ctrl,
  input  logic          wr_back,
  input  logic [CW-1:0] wdata,
  output ctrl_t         ctrl,
  output logic [CW-1:0] load_val,
  output logic [CW-1:0] back_val,
  output logic [CW-1:0] live,
  output logic          expire
);

  localparam logic [CW-1:0] LOW_MASK = {{(CW-HW){1'b0}}, {HW{1'b1}}};

  logic [CW-1:0] count_q;
  logic [CW-1:0] dec_val;
  logic [CW-1:0] next_val;
  logic          tick;
  logic          at_zero;
  logic          at_one;

  qtimer_prescale #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .restart (wr_ctrl),
    .run     (ctrl.en),
    .code    (ctrl.ps),
    .tick    (tick)
  );

  always_comb begin
    live    = ctrl.wide ? count_q : (count_q & LOW_MASK);
    at_zero = (live == '0);
    at_one  = (live == CW'(1));
    if (ctrl.wide) begin
      dec_val = count_q - CW'(1);
    end else begin
      dec_val = {count_q[CW-1:HW], count_q[HW-1:0] - HW'(1)};
    end
    if (at_zero && ctrl.one) begin
      next_val = count_q;
    end else if (at_zero && ctrl.per) begin
      next_val = back_val;
    end else begin
      next_val = dec_val;
    end
    expire = tick && at_one;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      load_val <= '0;
      back_val <= '0;
      count_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl <= byte_to_ctrl(wdata[7:0]);
      end
      if (wr_back) begin
        back_val <= wdata;
      end
      if (wr_load) begin
        load_val <= wdata;
        count_q  <= wdata;
      end else if (tick) begin
        count_q  <= next_val;
      end
    end
  end

endmodule

// File: rtl/qtimer_irqbank.sv
module qtimer_irqbank #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_mask,
  input  logic              wr_clr,
  input  logic [NUM_CH-1:0] wbits,
  input  logic [NUM_CH-1:0] expire,
  output logic [NUM_CH-1:0] mask,
  output logic [NUM_CH-1:0] ris,
  output logic              irq
);

  logic [NUM_CH-1:0] clr_bits;

  assign clr_bits = wr_clr ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
      ris  <= '0;
      irq  <= 1'b0;
    end else begin
      if (wr_mask) begin
        mask <= wbits;
      end
      ris <= (ris & ~clr_bits) | expire;
      irq <= |(ris & mask);
    end
  end

endmodule

// File: rtl/qtimer_top.sv
module qtimer_top
  import qtimer_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CW     = 32,
  parameter int unsigned HW     = 16,
  parameter int unsigned AW     = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic          irq
);

  localparam int unsigned GW = AW - 4;

  logic          aligned;
  logic [GW-1:0] grp;
  logic [1:0]    sub;
  logic          shared_hit;
  logic          wr_mask;
  logic          wr_clr;

  assign aligned    = (addr[1:0] == 2'b00);
  assign grp        = addr[AW-1:4];
  assign sub        = addr[3:2];
  assign shared_hit = aligned && (grp == '0);
  assign wr_mask    = wr_en && shared_hit && (sub == SUB_MASK);
  assign wr_clr     = wr_en && shared_hit && (sub == SUB_CLR);

  logic  [NUM_CH-1:0][CW-1:0] ch_load;
  logic  [NUM_CH-1:0][CW-1:0] ch_back;
  logic  [NUM_CH-1:0][CW-1:0] ch_live;
  ctrl_t [NUM_CH-1:0]         ch_ctrl;
  logic  [NUM_CH-1:0]         ch_expire;
  logic  [NUM_CH-1:0]         ch_hit;
  logic  [NUM_CH-1:0]         mask_q;
  logic  [NUM_CH-1:0]         ris_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign ch_hit[g] = aligned && (grp == GW'(g + 1));

    qtimer_chan #(.CW(CW), .HW(HW), .DIV_W(DIV_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .wr_load  (wr_en && ch_hit[g] && (sub == SUB_LOAD)),
      .wr_ctrl  (wr_en && ch_hit[g] && (sub == SUB_CTRL)),
      .wr_back  (wr_en && ch_hit[g] && (sub == SUB_BACK)),
      .wdata    (wdata),
      .ctrl     (ch_ctrl[g]),
      .load_val (ch_load[g]),
      .back_val (ch_back[g]),
      .live     (ch_live[g]),
      .expire   (ch_expire[g])
    );
  end

  qtimer_irqbank #(.NUM_CH(NUM_CH)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .wr_mask (wr_mask),
    .wr_clr  (wr_clr),
    .wbits   (wdata[NUM_CH-1:0]),
    .expire  (ch_expire),
    .mask    (mask_q),
    .ris     (ris_q),
    .irq     (irq)
  );

  logic [CW-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (shared_hit) begin
      case (sub)
        SUB_MASK: rd_next = CW'(mask_q);
        SUB_RAW:  rd_next = CW'(ris_q);
        SUB_MSKD: rd_next = CW'(ris_q & mask_q);
        default:  rd_next = '0;
      endcase
    end
    for (int k = 0; k < NUM_CH; k++) begin
      if (ch_hit[k]) begin
        case (sub)
          SUB_LOAD:  rd_next = ch_load[k];
          SUB_COUNT: rd_next = ch_live[k];
          SUB_CTRL:  rd_next = CW'(ctrl_to_byte(ch_ctrl[k]));
          default:   rd_next = ch_back[k];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= rd_next;
    end
  end

endmodule

// File: rtl/qtimer_sva.sv
module qtimer_sva
  import qtimer_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CW     = 32,
  parameter int unsigned AW     = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      wr_en,
  input logic [AW-1:0]             addr,
  input logic [NUM_CH-1:0]         wbits,
  input logic                      irq,
  input logic [NUM_CH-1:0]         mask,
  input logic [NUM_CH-1:0]         ris,
  input logic [NUM_CH-1:0]         expire,
  input logic [NUM_CH-1:0][CW-1:0] live,
  input ctrl_t [NUM_CH-1:0]        ctrl
);

  localparam int unsigned GW = AW - 4;

  logic clr_wr;
  assign clr_wr = wr_en && (addr[1:0] == 2'b00) && (addr[AW-1:4] == '0) && (addr[3:2] == SUB_CLR);

  // R11: with no bit masked in, the interrupt stays low on the next edge
  a_r11_irq_masked: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> !irq);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    logic ld_wr;
    logic cw_wr;
    assign ld_wr = wr_en && (addr[1:0] == 2'b00) && (addr[AW-1:4] == GW'(i + 1)) && (addr[3:2] == SUB_LOAD);
    assign cw_wr = wr_en && (addr[1:0] == 2'b00) && (addr[AW-1:4] == GW'(i + 1)) && (addr[3:2] == SUB_CTRL);

    // R5: a raw status bit only rises after its counter expired
    a_r5_status_source: assert property (@(posedge clk) disable iff (rst)
      $rose(ris[i]) |-> $past(expire[i]));

    // R12: a written clear bit empties the status unless a new expiry arrives
    a_r12_clear_bit: assert property (@(posedge clk) disable iff (rst)
      (clr_wr && wbits[i] && !expire[i]) |=> !ris[i]);

    // R10: disabled counter holds its value
    a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
      (!ctrl[i].en && !ld_wr && !cw_wr) |=> $stable(live[i]));

    // R8: one-shot counter at zero stays at zero
    a_r8_oneshot_hold: assert property (@(posedge clk) disable iff (rst)
      (ctrl[i].en && ctrl[i].one && (live[i] == '0) && !ld_wr && !cw_wr) |=> (live[i] == '0));

    // R4: a running 32-bit counter above one moves by at most one step
    a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
      (ctrl[i].en && ctrl[i].wide && (live[i] > CW'(1)) && !ld_wr && !cw_wr)
      |=> ((live[i] == $past(live[i])) || (live[i] == $past(live[i]) - CW'(1))));

    // R6: an undivided free-running counter changes every cycle
    a_r6_freerun_moves: assert property (@(posedge clk) disable iff (rst)
      (ctrl[i].en && !ctrl[i].per && !ctrl[i].one && (ctrl[i].ps == 2'b00) && !ld_wr && !cw_wr)
      |=> (live[i] != $past(live[i])));
  end

endmodule

bind qtimer_top qtimer_sva #(.NUM_CH(NUM_CH), .CW(CW), .AW(AW)) u_sva (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .addr   (addr),
  .wbits  (wdata[NUM_CH-1:0]),
  .irq    (irq),
  .mask   (mask_q),
  .ris    (ris_q),
  .expire (ch_expire),
  .live   (ch_live),
  .ctrl   (ch_ctrl)
);

// File: tb/test_qtimer_top.sv
module test_qtimer_top;

  localparam int NUM_CH = 4;
  localparam int CW     = 32;
  localparam int AW     = 8;
  localparam int NVEC   = 22;

  logic          clk   = 1'b0;
  logic          rst   = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr  = '0;
  logic [CW-1:0] wdata = '0;
  logic [CW-1:0] rdata;
  logic          irq;

  always #4 clk = ~clk;

  qtimer_top #(.NUM_CH(NUM_CH), .CW(CW), .AW(AW)) i_qtimer_top (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .irq   (irq)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // {is_read, addr, wdata, expected}
  localparam logic [72:0] VEC [NVEC] = '{
    {1'b0, 8'h10, 32'h1234_5678, 32'h0},           // R3 load ch0
    {1'b1, 8'h10, 32'h0,         32'h1234_5678},   // R3 readback
    {1'b1, 8'h14, 32'h0,         32'h0000_5678},   // R9 16-bit view
    {1'b0, 8'h18, 32'h0000_0002, 32'h0},           // ch0 wide, disabled
    {1'b1, 8'h14, 32'h0,         32'h1234_5678},   // R9 32-bit view
    {1'b1, 8'h18, 32'h0,         32'h0000_0002},   // R2 control readback
    {1'b0, 8'h28, 32'h0000_003C, 32'h0},           // R2 undefined bits
    {1'b1, 8'h28, 32'h0,         32'h0000_000C},   // R2 undefined bits dropped
    {1'b0, 8'h3C, 32'hAAAA_5555, 32'h0},           // R1 background ch2
    {1'b1, 8'h3C, 32'h0,         32'hAAAA_5555},   // R1 background readback
    {1'b1, 8'h34, 32'h0,         32'h0},           // R7 count untouched
    {1'b0, 8'h00, 32'hFFFF_FFFF, 32'h0},           // R1 mask
    {1'b1, 8'h00, 32'h0,         32'h0000_000F},   // R1 only channel bits
    {1'b1, 8'h08, 32'h0,         32'h0},           // R11 no status
    {1'b1, 8'h0C, 32'h0,         32'h0},           // R1 clear reads zero
    {1'b1, 8'h60, 32'h0,         32'h0},           // R1 unmapped
    {1'b0, 8'h12, 32'hDEAD_BEEF, 32'h0},           // R1 misaligned write
    {1'b1, 8'h12, 32'h0,         32'h0},           // R1 misaligned read
    {1'b1, 8'h10, 32'h0,         32'h1234_5678},   // R1 misaligned write ignored
    {1'b0, 8'h00, 32'h0,         32'h0},
    {1'b0, 8'h28, 32'h0,         32'h0},
    {1'b0, 8'h18, 32'h0,         32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr  = a;
    wdata = d;
    wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdchk(input logic [7:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    addr = a;
    @(posedge clk);
    #1 d = rdata;
    chk(req, d, exp);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // reset state (R2)
    chk("R2 reset irq", 32'(irq), 32'h0);
    rdchk(8'h18, 32'h0, "R2 reset ctrl");
    rdchk(8'h04, 32'h0, "R2 reset status");
    chk("R2 reset rdata", rdata, 32'h0);

    // register table (R1 R2 R3 R7 R9 R11)
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][72]) begin
        rdchk(VEC[v][71:64], VEC[v][31:0], $sformatf("R1 R2 R3 table vector %0d", v));
      end else begin
        wr(VEC[v][71:64], VEC[v][63:32]);
      end
    end

    // R5 R8: one-shot /1, load 5, expiry at 5th edge, irq one later
    wr(8'h00, 32'h2);
    wr(8'h20, 32'd5);
    wr(8'h28, 32'h83);
    repeat (5) @(posedge clk);
    #1 chk("R5 irq before", 32'(irq), 32'h0);
    @(posedge clk);
    #1 chk("R5 irq after", 32'(irq), 32'h1);
    @(negedge clk);
    rdchk(8'h04, 32'h2, "R5 raw status");
    idle(10);
    rdchk(8'h24, 32'h0, "R8 one-shot holds zero");
    chk("R11 irq held", 32'(irq), 32'h1);
    wr(8'h0C, 32'h2);
    idle(2);
    chk("R12 irq cleared", 32'(irq), 32'h0);
    rdchk(8'h04, 32'h0, "R12 status cleared");
    wr(8'h28, 32'h0);

    // R4: divide by 16, load 2
    wr(8'h00, 32'h1);
    wr(8'h10, 32'd2);
    wr(8'h18, 32'h87);
    repeat (32) @(posedge clk);
    #1 chk("R4 div16 before", 32'(irq), 32'h0);
    @(posedge clk);
    #1 chk("R4 div16 after", 32'(irq), 32'h1);
    @(negedge clk);
    wr(8'h18, 32'h0);
    wr(8'h0C, 32'hF);

    // R4: divide by 256, load 1
    wr(8'h00, 32'h2);
    wr(8'h20, 32'd1);
    wr(8'h28, 32'h8B);
    repeat (256) @(posedge clk);
    #1 chk("R4 div256 before", 32'(irq), 32'h0);
    @(posedge clk);
    #1 chk("R4 div256 after", 32'(irq), 32'h1);
    @(negedge clk);
    wr(8'h28, 32'h0);
    wr(8'h0C, 32'hF);
    wr(8'h00, 32'h0);

    // R6: free-running 32-bit wrap, frozen at third edge
    wr(8'h40, 32'd1);
    wr(8'h48, 32'h82);
    idle(2);
    wr(8'h48, 32'h02);
    rdchk(8'h44, 32'hFFFF_FFFE, "R6 wide wrap");
    rdchk(8'h04, 32'h8, "R5 status while masked off");
    chk("R11 irq masked off", 32'(irq), 32'h0);
    rdchk(8'h08, 32'h0, "R11 masked status zero");
    idle(20);
    rdchk(8'h44, 32'hFFFF_FFFE, "R10 frozen count");

    // R9 R6: 16-bit free-running wrap
    wr(8'h40, 32'd1);
    wr(8'h48, 32'h80);
    idle(2);
    wr(8'h48, 32'h00);
    rdchk(8'h44, 32'h0000_FFFE, "R9 narrow wrap");

    // R11: unmask pending status
    wr(8'h00, 32'h8);
    idle(1);
    chk("R11 irq after unmask", 32'(irq), 32'h1);
    rdchk(8'h08, 32'h8, "R11 masked status");

    // R7: periodic reload from background value 2
    wr(8'h30, 32'd3);
    wr(8'h3C, 32'd2);
    wr(8'h38, 32'hC2);
    idle(3);
    wr(8'h38, 32'h42);
    rdchk(8'h34, 32'd2, "R7 reload");
    wr(8'h38, 32'hC2);
    idle(3);
    wr(8'h38, 32'h42);
    rdchk(8'h34, 32'd1, "R7 period");

    // R12: partial clear keeps other bits
    rdchk(8'h04, 32'hC, "R12 two bits pending");
    wr(8'h0C, 32'h4);
    rdchk(8'h04, 32'h8, "R12 partial clear");
    wr(8'h0C, 32'hF);
    rdchk(8'h04, 32'h0, "R12 full clear");

    // R8: one-shot overrides periodic
    wr(8'h30, 32'd1);
    wr(8'h38, 32'hC3);
    idle(10);
    rdchk(8'h34, 32'h0, "R8 one-shot wins");
    wr(8'h38, 32'h0);
    wr(8'h0C, 32'hF);

    // R9: expiry at 16-bit zero with upper half set
    wr(8'h00, 32'h1);
    wr(8'h10, 32'h0001_0001);
    wr(8'h18, 32'h81);
    idle(3);
    chk("R9 narrow expiry irq", 32'(irq), 32'h1);
    rdchk(8'h14, 32'h0, "R9 narrow count");

    // R10: repeated reads change nothing
    rdchk(8'h04, 32'h1, "R10 read one");
    rdchk(8'h04, 32'h1, "R10 read two");
    wr(8'h18, 32'h0);

    // R3: load while running
    wr(8'h40, 32'h100);
    wr(8'h48, 32'h82);
    idle(2);
    wr(8'h40, 32'h50);
    rdchk(8'h44, 32'h50, "R3 load while running");
    wr(8'h48, 32'h0);

    finish_run();
  end

endmodule